// File: doc/BRIEF.md
# Six-Instruction Single-Cycle Core

A small in-order processor that completes one instruction on every rising clock edge. It has no pipeline. Each cycle it reads the instruction word at the program counter, decodes it, reads two source registers and performs the operation. On the same edge it writes the result and moves the program counter on. Program and data live in two separate internal arrays, so a store can never alter the instruction stream. The program array is filled through a write port while the core is held in reset.

The instruction set has six kinds. Two write a register from the instruction word or from the current PC. One is a register-only arithmetic operation. Branching uses a single jump-if-zero whose target address is taken from a register. The last two are a load and a store, which address data memory through a register. A debug port shows the PC of the instruction now executing and the register-file write it will perform. A bench can use it to compare every retired instruction against a model.

Reset is asynchronous and active low. Its release is synchronised by two flops inside the core. The instruction at address 0 becomes current two rising edges after `rst_n` goes high.

Top module: `mrisc_core`

## Requirements
- R1: While reset is applied, and for one rising edge after `rst_n` rises, the debug PC reads 0 and no register write is shown. After the second edge the instruction at address 0 is current, and every register reads as zero.
- R2: Instructions are 22 bits wide with the opcode in [21:19] and the destination register in [18:16]. Opcode 0 (load-constant) writes the 16-bit constant in [15:0] to the destination register.
- R3: Opcode 1 (load-PC) writes the address of that same instruction to the destination register.
- R4: Opcode 2 (arithmetic) uses the sources in [15:13] and [12:10] and writes a 16-bit result selected by the function field in [9:7]. The codes are 0 add, 1 subtract (first minus second), 2 and, 3 or, 4 xor. Codes 5 to 7 write zero, and all results wrap modulo 2^16.
- R5: Opcode 3 (jump-if-zero) tests the register in [15:13]. When it is zero the next PC is the value of the register in [12:10]. Otherwise the next PC is PC+1. No register is written.
- R6: Opcode 4 (load) writes data word `mem[src1]` to the destination, with the address taken from the low bits of the register in [15:13].
- R7: Opcode 5 (store) writes the register in [12:10] to data word `mem[src1]` and writes no register. The instruction stored at the same numeric address still executes unchanged.
- R8: Opcodes 6 and 7 write nothing and only advance the PC.
- R9: Every instruction other than jump-if-zero advances the PC by exactly one, with 16-bit wrap. Exactly one instruction retires per cycle, in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Program array write enable |
| prog_addr | input | 6 | Program array write address |
| prog_data | input | 22 | Instruction word to write |
| dbg_pc | output | 16 | PC of the instruction currently executing |
| dbg_rf_we | output | 1 | Register write taking place this cycle |
| dbg_rf_waddr | output | 3 | Destination register of that write |
| dbg_rf_wdata | output | 16 | Value being written |

## Verification
The bound checker watches the control flow on every cycle. It confirms the plus-one step after each non-jump and the jump target or fall-through. It also confirms that jump, store and the reserved opcodes write nothing, and that the two immediate-style writes carry the constant or the PC. Arithmetic results, load data returned after a store, the isolation of program memory from stores, and the zeroed register file after reset depend on earlier history. Only the bench's reference model shows these, by replaying each instruction and comparing every cycle. The program covers all five functions, a wrapped sum, both jump outcomes, skipped code and a second reset.

// File: rtl/mrisc_pkg.sv
package mrisc_pkg;

  typedef enum logic [2:0] {
    OP_LI   = 3'd0,
    OP_LPC  = 3'd1,
    OP_ALU  = 3'd2,
    OP_JZ   = 3'd3,
    OP_LD   = 3'd4,
    OP_ST   = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    WB_IMM = 2'd0,
    WB_PC  = 2'd1,
    WB_ALU = 2'd2,
    WB_MEM = 2'd3
  } wb_sel_e;

  localparam logic [2:0] FN_ADD = 3'd0;
  localparam logic [2:0] FN_SUB = 3'd1;
  localparam logic [2:0] FN_AND = 3'd2;
  localparam logic [2:0] FN_OR  = 3'd3;
  localparam logic [2:0] FN_XOR = 3'd4;

  typedef struct packed {
    op_e     op;
    logic    rf_we;
    wb_sel_e wb_sel;
    logic    is_jz;
    logic    is_st;
  } ctrl_t;

endpackage

// File: rtl/mrisc_decode.sv
module mrisc_decode
  import mrisc_pkg::*;
(
  input  logic [2:0] op_bits,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl        = '0;
    ctrl.op     = op_e'(op_bits);
    ctrl.wb_sel = WB_IMM;
    unique case (op_e'(op_bits))
      OP_LI:   begin ctrl.rf_we = 1'b1; ctrl.wb_sel = WB_IMM; end
      OP_LPC:  begin ctrl.rf_we = 1'b1; ctrl.wb_sel = WB_PC;  end
      OP_ALU:  begin ctrl.rf_we = 1'b1; ctrl.wb_sel = WB_ALU; end
      OP_LD:   begin ctrl.rf_we = 1'b1; ctrl.wb_sel = WB_MEM; end
      OP_JZ:   ctrl.is_jz = 1'b1;
      OP_ST:   ctrl.is_st = 1'b1;
      default: ctrl.rf_we = 1'b0;
    endcase
  end

endmodule

// File: rtl/mrisc_alu.sv
module mrisc_alu
  import mrisc_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  logic [2:0]      fn,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);

  always_comb begin
    unique case (fn)
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/mrisc_regfile.sv
module mrisc_regfile #(
  parameter int XLEN = 16,
  parameter int NREG = 8,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RAW-1:0]  waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RAW-1:0]  raddr_a,
  output logic [XLEN-1:0] rdata_a,
  input  logic [RAW-1:0]  raddr_b,
  output logic [XLEN-1:0] rdata_b
);

  logic [NREG-1:0][XLEN-1:0] regs_q;
  logic [NREG-1:0]           wen_vec;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      wen_vec[i] = we && (waddr == RAW'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wen_vec[i]) regs_q[i] <= wdata;
      end
    end
  end

  assign rdata_a = regs_q[raddr_a];
  assign rdata_b = regs_q[raddr_b];

endmodule

// File: rtl/mrisc_core.sv
module mrisc_core
  import mrisc_pkg::*;
#(
  parameter int XLEN        = 16,
  parameter int NREG        = 8,
  parameter int IMEM_DEPTH  = 64,
  parameter int DMEM_DEPTH  = 64,
  localparam int RAW        = $clog2(NREG),
  localparam int IAW        = $clog2(IMEM_DEPTH),
  localparam int DAW        = $clog2(DMEM_DEPTH),
  localparam int ILEN       = 3 + RAW + XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog_we,
  input  logic [IAW-1:0]  prog_addr,
  input  logic [ILEN-1:0] prog_data,
  output logic [XLEN-1:0] dbg_pc,
  output logic            dbg_rf_we,
  output logic [RAW-1:0]  dbg_rf_waddr,
  output logic [XLEN-1:0] dbg_rf_wdata
);

  localparam int OP_HI  = ILEN - 1;
  localparam int RD_HI  = OP_HI - 3;
  localparam int RS1_HI = RD_HI - RAW;
  localparam int RS2_HI = RS1_HI - RAW;
  localparam int FN_HI  = RS2_HI - RAW;

  // reset release synchroniser
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  // program array (written only through the load port)
  logic [ILEN-1:0] imem_q [IMEM_DEPTH];

  always_ff @(posedge clk) begin
    if (prog_we) imem_q[prog_addr] <= prog_data;
  end

  // fetch and decode
  logic [XLEN-1:0] pc_q, pc_d;
  logic [ILEN-1:0] instr;
  ctrl_t           ctrl;
  op_e             cur_op;
  logic [RAW-1:0]  rd_idx, rs1_idx, rs2_idx;
  logic [2:0]      fn;
  logic [XLEN-1:0] imm;

  assign instr   = imem_q[pc_q[IAW-1:0]];
  assign rd_idx  = instr[RD_HI  -: RAW];
  assign rs1_idx = instr[RS1_HI -: RAW];
  assign rs2_idx = instr[RS2_HI -: RAW];
  assign fn      = instr[FN_HI  -: 3];
  assign imm     = instr[XLEN-1:0];

  mrisc_decode u_dec (
    .op_bits (instr[OP_HI -: 3]),
    .ctrl    (ctrl)
  );
  assign cur_op = ctrl.op;

  // operands
  logic [XLEN-1:0] rs1_val, rs2_val, alu_y, ld_val, wb_val;
  logic            rf_we;

  assign rf_we = ctrl.rf_we & rst_q;

  mrisc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst_n   (rst_q),
    .we      (rf_we),
    .waddr   (rd_idx),
    .wdata   (wb_val),
    .raddr_a (rs1_idx),
    .rdata_a (rs1_val),
    .raddr_b (rs2_idx),
    .rdata_b (rs2_val)
  );

  mrisc_alu #(.XLEN(XLEN)) u_alu (
    .fn (fn),
    .a  (rs1_val),
    .b  (rs2_val),
    .y  (alu_y)
  );

  // data array
  logic [XLEN-1:0] dmem_q [DMEM_DEPTH];
  logic            st_en;

  assign st_en  = ctrl.is_st & rst_q;
  assign ld_val = dmem_q[rs1_val[DAW-1:0]];

  always_ff @(posedge clk) begin
    if (st_en) dmem_q[rs1_val[DAW-1:0]] <= rs2_val;
  end

  // write-back select
  always_comb begin
    unique case (ctrl.wb_sel)
      WB_IMM:  wb_val = imm;
      WB_PC:   wb_val = pc_q;
      WB_ALU:  wb_val = alu_y;
      default: wb_val = ld_val;
    endcase
  end

  // next PC
  always_comb begin
    if (ctrl.is_jz && (rs1_val == '0)) pc_d = rs2_val;
    else                               pc_d = pc_q + XLEN'(1);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign dbg_pc       = pc_q;
  assign dbg_rf_we    = rf_we;
  assign dbg_rf_waddr = rd_idx;
  assign dbg_rf_wdata = wb_val;

endmodule

// File: rtl/mrisc_core_chk.sv
module mrisc_core_chk
  import mrisc_pkg::*;
#(
  parameter int XLEN = 16,
  parameter int RAW  = 3
) (
  input logic            clk,
  input logic            rst_q,
  input op_e             op,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] rs1_v,
  input logic [XLEN-1:0] rs2_v,
  input logic [XLEN-1:0] imm,
  input logic            rf_we,
  input logic [XLEN-1:0] wdata
);

  // R9
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (op != OP_JZ) |=> (pc == XLEN'($past(pc) + 1'b1)));

  // R5
  jz_taken_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (op == OP_JZ && rs1_v == '0) |=> (pc == $past(rs2_v)));

  // R5
  jz_fall_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (op == OP_JZ && rs1_v != '0) |=> (pc == XLEN'($past(pc) + 1'b1)));

  // R8
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (op == OP_JZ || op == OP_ST || op == OP_RSV6 || op == OP_RSV7) |-> !rf_we);

  // R2
  li_value_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (op == OP_LI) |-> (rf_we && wdata == imm));

  // R3
  lpc_value_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (op == OP_LPC) |-> (rf_we && wdata == pc));

endmodule

bind mrisc_core mrisc_core_chk #(.XLEN(XLEN), .RAW(RAW)) u_chk (
  .clk   (clk),
  .rst_q (rst_q),
  .op    (cur_op),
  .pc    (pc_q),
  .rs1_v (rs1_val),
  .rs2_v (rs2_val),
  .imm   (imm),
  .rf_we (rf_we),
  .wdata (wb_val)
);

// File: tb/mrisc_core_bench.sv
module mrisc_core_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_we = 1'b0;
  logic [5:0]  prog_addr = '0;
  logic [21:0] prog_data = '0;
  logic [15:0] dbg_pc;
  logic        dbg_rf_we;
  logic [2:0]  dbg_rf_waddr;
  logic [15:0] dbg_rf_wdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mrisc_core u_mrisc_core (
    .clk, .rst_n, .prog_we, .prog_addr, .prog_data,
    .dbg_pc, .dbg_rf_we, .dbg_rf_waddr, .dbg_rf_wdata
  );

  logic [21:0] prog [64];
  logic [15:0] m_reg [8];
  logic [15:0] m_mem [int];
  int          m_pc;

  function automatic logic [21:0] rr(int op, int rd, int a, int b, int fn);
    return {3'(op), 3'(rd), 3'(a), 3'(b), 3'(fn), 7'd0};
  endfunction

  function automatic logic [21:0] li(int rd, logic [15:0] v);
    return {3'd0, 3'(rd), v};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one reference step: compare at negedge, then retire into the model
  task automatic step(bit first);
    logic [21:0] w = prog[m_pc % 64];
    int op = int'(w[21:19]);
    int rd = int'(w[18:16]);
    logic [15:0] a = m_reg[w[15:13]];
    logic [15:0] b = m_reg[w[12:10]];
    int fn = int'(w[9:7]);
    bit we = 1'b0;
    logic [15:0] v = '0;
    int nxt = (m_pc + 1) % 65536;
    string req;
    case (op)
      0: begin we = 1; v = w[15:0]; req = "R2"; end
      1: begin we = 1; v = 16'(m_pc); req = "R3"; end
      2: begin
        we = 1; req = first ? "R1/R4" : "R4";
        case (fn)
          0: v = a + b;
          1: v = a - b;
          2: v = a & b;
          3: v = a | b;
          4: v = a ^ b;
          default: v = '0;
        endcase
      end
      3: begin req = "R5"; if (a == 0) nxt = int'(b); end
      4: begin we = 1; v = m_mem[int'(a) % 64]; req = "R6"; end
      5: begin req = "R7"; end
      default: req = "R8";
    endcase
    chk(dbg_pc == 16'(m_pc), (op == 3) ? "R5" : "R9", "pc", dbg_pc, 16'(m_pc));
    chk(dbg_rf_we == we, req, "rf_we", 16'(dbg_rf_we), 16'(we));
    if (we) begin
      chk(dbg_rf_waddr == 3'(rd), req, "waddr", 16'(dbg_rf_waddr), 16'(rd));
      chk(dbg_rf_wdata === v, req, "wdata", dbg_rf_wdata, v);
    end
    if (we) m_reg[rd] = v;
    if (op == 5) m_mem[int'(a) % 64] = b;
    m_pc = nxt;
    @(negedge clk);
  endtask

  task automatic reset_and_hold();
    rst_n = 1'b0;
    @(negedge clk);
    chk(dbg_pc == 16'd0, "R1", "pc in reset", dbg_pc, 16'd0);
    chk(dbg_rf_we == 1'b0, "R1", "we in reset", 16'(dbg_rf_we), 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dbg_pc == 16'd0, "R1", "pc hold", dbg_pc, 16'd0);
    chk(dbg_rf_we == 1'b0, "R1", "we hold", 16'(dbg_rf_we), 16'd0);
    @(negedge clk);
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_pc = 0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) prog[i] = {3'd7, 19'd0};
    prog[0]  = rr(2, 3, 0, 1, 0);      // zero registers after reset
    prog[1]  = li(1, 16'h0005);
    prog[2]  = li(2, 16'hFFFD);
    prog[3]  = rr(2, 3, 1, 2, 0);
    prog[4]  = rr(2, 4, 2, 1, 1);
    prog[5]  = rr(2, 5, 1, 2, 2);
    prog[6]  = rr(2, 6, 1, 2, 3);
    prog[7]  = rr(2, 7, 1, 2, 4);
    prog[8]  = rr(2, 3, 1, 2, 6);      // undefined function code
    prog[9]  = li(0, 16'd20);
    prog[10] = rr(5, 0, 0, 1, 0);      // store
    prog[11] = rr(4, 5, 0, 0, 0);      // load back
    prog[12] = rr(1, 6, 0, 0, 0);      // load-PC
    prog[13] = li(7, 16'd20);
    prog[14] = rr(3, 0, 1, 7, 0);      // not taken
    prog[15] = {3'd6, 19'h1FFFF};      // reserved opcode
    prog[16] = rr(3, 0, 3, 7, 0);      // taken to 20
    prog[17] = li(1, 16'h7777);
    prog[18] = li(1, 16'h7777);
    prog[19] = li(1, 16'h7777);
    prog[20] = li(2, 16'hFFFF);
    prog[21] = rr(2, 3, 2, 2, 0);      // wrapping add
    prog[22] = li(0, 16'd24);
    prog[23] = rr(5, 0, 0, 2, 0);      // store at same number as next instr
    prog[24] = li(5, 16'h1234);
    prog[25] = rr(4, 6, 0, 0, 0);
    prog[26] = li(7, 16'd28);
    prog[27] = li(1, 16'h0000);
    prog[28] = rr(3, 0, 1, 7, 0);      // spin

    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      prog_we = 1'b1; prog_addr = 6'(i); prog_data = prog[i];
      @(negedge clk);
    end
    prog_we = 1'b0;

    reset_and_hold();
    for (int i = 0; i < 40; i++) step(i == 0);

    reset_and_hold();
    for (int i = 0; i < 12; i++) step(i == 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule